// File: doc/BRIEF.md
# Nibble-Addressed Pointer and Timer Register Access

This block keeps three 12-bit registers: two timer/counter values (called A and B here) and a data pointer. It also keeps a 4-bit stack pointer. A 4-bit accumulator path reads or writes any one 4-bit nibble of these registers. The block decodes a two-byte load/store instruction family. The first byte picks the direction. The second byte picks both the register and the nibble. One second-byte code is reserved for the stack pointer.

The core presents both instruction bytes together with `op_valid`. Any store lands at the clock edge that samples the instruction, so the exported register values change in the next cycle. A load returns the selected nibble one cycle after issue. It raises a write strobe for the accumulator and the flag updates the core has to apply. The timer counting logic and the memory addressing logic are downstream users of the full 12-bit values on the export ports. Those users are not part of this block.

Top module: `nibble_ptr_regs`

## Requirements
- R1: While `rst_n` is low, both timers, the data pointer and the stack pointer are 0. All response strobes (`acc_we`, `zf_we`, `sf_we`) are 0.
- R2: A store (first byte 0x69) with second byte 0xF4, 0xF5 or 0xF6 writes `acc_in` into timer A bits [3:0], [7:4] or [11:8]. The other nibbles keep their values. `ta_out` shows the result one cycle after issue.
- R3: A store with second byte 0xF8, 0xF9 or 0xFA writes timer B bits [3:0], [7:4] or [11:8]. The other nibbles are unchanged.
- R4: A store with second byte 0xFC, 0xFD or 0xFE writes data pointer bits [3:0], [7:4] or [11:8]. The other nibbles are unchanged.
- R5: Second byte 0xFF addresses the 4-bit stack pointer. A store copies `acc_in` into it, and a load returns it.
- R6: A load (first byte 0x6A) with any of the ten codes above raises `acc_we` for one cycle, one cycle after issue. `acc_out` then carries the addressed nibble as it was in the issue cycle.
- R7: A load raises `zf_we` together with `acc_we`. `zf_out` is 1 exactly when the loaded nibble is 0.
- R8: A store raises neither `acc_we` nor `zf_we`, so the accumulator and the zero flag are left untouched. No carry update is produced by any instruction.
- R9: Every decoded load or store raises `sf_we` with `sf_out` = 1, one cycle after issue.
- R10: A first byte other than 0x6A/0x69, or a second byte outside the ten listed codes (for example 0xF7, 0xFB, 0xF0, 0xE4), writes nothing and raises no strobe.
- R11: With `op_valid` low, the byte inputs are ignored. No register changes and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction bytes are valid this cycle |
| op_first | input | 8 | First instruction byte (direction) |
| op_second | input | 8 | Second instruction byte (register and nibble) |
| acc_in | input | 4 | Accumulator value for stores |
| acc_we | output | 1 | Accumulator write strobe (loads) |
| acc_out | output | 4 | Nibble returned by a load |
| zf_we | output | 1 | Zero flag write strobe |
| zf_out | output | 1 | New zero flag value |
| sf_we | output | 1 | Status flag write strobe |
| sf_out | output | 1 | New status flag value |
| ta_out | output | 12 | Timer A value |
| tb_out | output | 12 | Timer B value |
| dp_out | output | 12 | Data pointer value |
| sp_out | output | 4 | Stack pointer value |

## Verification
A corrupted nibble or a wrong decode shows up on the 12-bit export ports one cycle after the store that caused it. A missing write shows up on the first load of that nibble that follows. A stray flag or accumulator strobe is visible in the cycle right after the faulty issue. A reference model compares every port on every clock, so a fault is caught within one cycle of when it can first be seen.

// File: rtl/nptr_pkg.sv
package nptr_pkg;
  localparam logic [7:0] OP_LOAD  = 8'h6A;
  localparam logic [7:0] OP_STORE = 8'h69;

  typedef enum logic [2:0] {T_NONE, T_TA, T_TB, T_DP, T_SP} tgt_e;

  typedef struct packed {
    logic       load;
    logic       store;
    tgt_e       tgt;
    logic [1:0] nib;
  } dec_t;

  // second byte: upper nibble 1111, bits [3:2] choose register, [1:0] nibble
  function automatic dec_t decode(input logic valid, input logic [7:0] b1,
                                  input logic [7:0] b2);
    dec_t d;
    d.load  = 1'b0;
    d.store = 1'b0;
    d.tgt   = T_NONE;
    d.nib   = b2[1:0];
    if (valid && b2[7:4] == 4'hF) begin
      case (b2[3:2])
        2'b01:   d.tgt = (b2[1:0] != 2'b11) ? T_TA : T_NONE;
        2'b10:   d.tgt = (b2[1:0] != 2'b11) ? T_TB : T_NONE;
        2'b11:   d.tgt = (b2[1:0] == 2'b11) ? T_SP : T_DP;
        default: d.tgt = T_NONE;
      endcase
      d.load  = (d.tgt != T_NONE) && (b1 == OP_LOAD);
      d.store = (d.tgt != T_NONE) && (b1 == OP_STORE);
      if (!d.load && !d.store) d.tgt = T_NONE;
    end
    return d;
  endfunction
endpackage

// File: rtl/nptr_nibreg.sv
module nptr_nibreg #(
  parameter int NIBBLE_W = 4,
  parameter int NIBBLES  = 3,
  localparam int REG_W   = NIBBLE_W * NIBBLES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          sel,
  input  logic [NIBBLE_W-1:0] wdata,
  output logic [REG_W-1:0]    q,
  output logic [NIBBLE_W-1:0] rdata
);
  for (genvar j = 0; j < NIBBLES; j++) begin : g_nib
    logic [NIBBLE_W-1:0] nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    nib_q <= '0;
      else if (we && sel == 2'(j))   nib_q <= wdata;
    end
    assign q[j*NIBBLE_W +: NIBBLE_W] = nib_q;
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < NIBBLES; j++)
      if (sel == 2'(j)) rdata = q[j*NIBBLE_W +: NIBBLE_W];
  end
endmodule

// File: rtl/nptr_resp.sv
module nptr_resp #(
  parameter int NIBBLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic                st,
  input  logic [NIBBLE_W-1:0] ld_data,
  output logic                acc_we,
  output logic [NIBBLE_W-1:0] acc_out,
  output logic                zf_we,
  output logic                zf_out,
  output logic                sf_we,
  output logic                sf_out
);
  function automatic logic nib_is_zero(input logic [NIBBLE_W-1:0] v);
    return ~|v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_we  <= 1'b0;
      acc_out <= '0;
      zf_we   <= 1'b0;
      zf_out  <= 1'b0;
      sf_we   <= 1'b0;
      sf_out  <= 1'b0;
    end else begin
      acc_we <= ld;
      zf_we  <= ld;
      sf_we  <= ld | st;
      sf_out <= ld | st;
      if (ld) begin
        acc_out <= ld_data;
        zf_out  <= nib_is_zero(ld_data);
      end
    end
  end
endmodule

// File: rtl/nibble_ptr_regs.sv
module nibble_ptr_regs
  import nptr_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  parameter int NIBBLES  = 3,
  localparam int REG_W   = NIBBLE_W * NIBBLES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [7:0]          op_first,
  input  logic [7:0]          op_second,
  input  logic [NIBBLE_W-1:0] acc_in,
  output logic                acc_we,
  output logic [NIBBLE_W-1:0] acc_out,
  output logic                zf_we,
  output logic                zf_out,
  output logic                sf_we,
  output logic                sf_out,
  output logic [REG_W-1:0]    ta_out,
  output logic [REG_W-1:0]    tb_out,
  output logic [REG_W-1:0]    dp_out,
  output logic [NIBBLE_W-1:0] sp_out
);
  localparam int NREGS = 3;

  dec_t dec;
  logic load_ev, store_ev;
  logic [NIBBLE_W-1:0] ld_data;
  logic [NIBBLE_W-1:0] rd [NREGS];
  logic [REG_W-1:0]    q  [NREGS];
  logic [NIBBLE_W-1:0] sp_q;

  assign dec      = decode(op_valid, op_first, op_second);
  assign load_ev  = dec.load;
  assign store_ev = dec.store;

  // slot 0 = timer A, 1 = timer B, 2 = data pointer
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam tgt_e SLOT_TGT = tgt_e'(3'(i + 1));
    nptr_nibreg #(.NIBBLE_W(NIBBLE_W), .NIBBLES(NIBBLES)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (store_ev && dec.tgt == SLOT_TGT),
      .sel   (dec.nib),
      .wdata (acc_in),
      .q     (q[i]),
      .rdata (rd[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           sp_q <= '0;
    else if (store_ev && dec.tgt == T_SP) sp_q <= acc_in;
  end

  always_comb begin
    case (dec.tgt)
      T_TA:    ld_data = rd[0];
      T_TB:    ld_data = rd[1];
      T_DP:    ld_data = rd[2];
      T_SP:    ld_data = sp_q;
      default: ld_data = '0;
    endcase
  end

  nptr_resp #(.NIBBLE_W(NIBBLE_W)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (load_ev),
    .st      (store_ev),
    .ld_data (ld_data),
    .acc_we  (acc_we),
    .acc_out (acc_out),
    .zf_we   (zf_we),
    .zf_out  (zf_out),
    .sf_we   (sf_we),
    .sf_out  (sf_out)
  );

  assign ta_out = q[0];
  assign tb_out = q[1];
  assign dp_out = q[2];
  assign sp_out = sp_q;
endmodule

// File: rtl/nptr_chk.sv
module nptr_chk #(
  parameter int NIBBLE_W = 4,
  parameter int NIBBLES  = 3,
  localparam int REG_W   = NIBBLE_W * NIBBLES
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic                load_ev,
  input logic                store_ev,
  input logic                acc_we,
  input logic [NIBBLE_W-1:0] acc_out,
  input logic                zf_we,
  input logic                zf_out,
  input logic                sf_we,
  input logic                sf_out,
  input logic [REG_W-1:0]    ta_out,
  input logic [REG_W-1:0]    tb_out,
  input logic [REG_W-1:0]    dp_out,
  input logic [NIBBLE_W-1:0] sp_out
);
  always @(posedge clk)
    if (!rst_n)
      a_r1_reset_clear: assert (ta_out == '0 && tb_out == '0 && dp_out == '0 && sp_out == '0);

  a_r2_regs_need_store: assert property (@(posedge clk) disable iff (!rst_n)
    !store_ev |=> $stable(ta_out) && $stable(tb_out) && $stable(dp_out) && $stable(sp_out));

  a_r6_load_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> acc_we);

  a_r7_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    zf_we |-> acc_we && (zf_out == (acc_out == '0)));

  a_r8_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev |=> !acc_we && !zf_we);

  a_r9_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev || store_ev) |=> sf_we && sf_out);

  a_r10_bad_code_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !load_ev && !store_ev) |=> !acc_we && !zf_we && !sf_we);

  a_r11_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !acc_we && !zf_we && !sf_we);
endmodule

bind nibble_ptr_regs nptr_chk #(.NIBBLE_W(NIBBLE_W), .NIBBLES(NIBBLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .load_ev(load_ev), .store_ev(store_ev),
  .acc_we(acc_we), .acc_out(acc_out), .zf_we(zf_we), .zf_out(zf_out),
  .sf_we(sf_we), .sf_out(sf_out), .ta_out(ta_out), .tb_out(tb_out),
  .dp_out(dp_out), .sp_out(sp_out)
);

// File: tb/nibble_ptr_regs_test.sv
module nibble_ptr_regs_test;
  logic clk = 0;
  logic rst_n = 0;
  logic op_valid = 0;
  logic [7:0] op_first = 0, op_second = 0;
  logic [3:0] acc_in = 0;
  logic acc_we, zf_we, zf_out, sf_we, sf_out;
  logic [3:0] acc_out, sp_out;
  logic [11:0] ta_out, tb_out, dp_out;

  int errors = 0;
  int checks = 0;

  int m_reg [3];
  int m_sp;
  int e_acc_we, e_acc, e_zf_we, e_zf, e_sf_we;

  always #10 clk = ~clk;

  nibble_ptr_regs uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_first(op_first),
    .op_second(op_second), .acc_in(acc_in), .acc_we(acc_we), .acc_out(acc_out),
    .zf_we(zf_we), .zf_out(zf_out), .sf_we(sf_we), .sf_out(sf_out),
    .ta_out(ta_out), .tb_out(tb_out), .dp_out(dp_out), .sp_out(sp_out)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic string pick(input string ovr, input string dflt);
    return (ovr.len() > 0) ? ovr : dflt;
  endfunction

  task automatic compare_all(input string ovr);
    chk(pick(ovr, "R6"), "acc_we", int'(acc_we), e_acc_we);
    if (e_acc_we != 0) chk(pick(ovr, "R6"), "acc_out", int'(acc_out), e_acc);
    chk(pick(ovr, "R7"), "zf_we", int'(zf_we), e_zf_we);
    if (e_zf_we != 0) chk(pick(ovr, "R7"), "zf_out", int'(zf_out), e_zf);
    chk(pick(ovr, "R9"), "sf_we", int'(sf_we), e_sf_we);
    if (e_sf_we != 0) chk(pick(ovr, "R9"), "sf_out", int'(sf_out), 1);
    chk(pick(ovr, "R2"), "ta_out", int'(ta_out), m_reg[0]);
    chk(pick(ovr, "R3"), "tb_out", int'(tb_out), m_reg[1]);
    chk(pick(ovr, "R4"), "dp_out", int'(dp_out), m_reg[2]);
    chk(pick(ovr, "R5"), "sp_out", int'(sp_out), m_sp);
  endtask

  // reference: behavioural restatement of the requirements
  task automatic model_step(input bit v, input int b1, input int b2, input int a);
    int slot, pos, val;
    bit is_ld, is_st, hit_sp;
    slot = -1; pos = 0; hit_sp = 0;
    is_ld = v && (b1 == 'h6A);
    is_st = v && (b1 == 'h69);
    if (b2 >= 'hF4 && b2 <= 'hF6) begin slot = 0; pos = b2 - 'hF4; end
    else if (b2 >= 'hF8 && b2 <= 'hFA) begin slot = 1; pos = b2 - 'hF8; end
    else if (b2 >= 'hFC && b2 <= 'hFE) begin slot = 2; pos = b2 - 'hFC; end
    else if (b2 == 'hFF) hit_sp = 1;
    if (slot < 0 && !hit_sp) begin is_ld = 0; is_st = 0; end
    e_acc_we = 0; e_zf_we = 0; e_sf_we = 0;
    if (is_ld) begin
      val = hit_sp ? m_sp : (m_reg[slot] / (1 << (4 * pos))) % 16;
      e_acc_we = 1; e_acc = val; e_zf_we = 1; e_zf = (val == 0) ? 1 : 0; e_sf_we = 1;
    end
    if (is_st) begin
      e_sf_we = 1;
      if (hit_sp) m_sp = a;
      else m_reg[slot] = (m_reg[slot] & ~(15 << (4 * pos))) | (a << (4 * pos));
    end
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic issue(input bit v, input int b1, input int b2, input int a, input string ovr);
    op_valid = v; op_first = 8'(b1); op_second = 8'(b2); acc_in = 4'(a);
    @(posedge clk);
    model_step(v, b1, b2, a);
    @(negedge clk);
    compare_all(ovr);
  endtask

  task automatic st(input int b2, input int a); issue(1, 'h69, b2, a, ""); endtask
  task automatic ld(input int b2);              issue(1, 'h6A, b2, 0, ""); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) m_reg[k] = 0;
    m_sp = 0; e_acc_we = 0; e_acc = 0; e_zf_we = 0; e_zf = 0; e_sf_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1;

    // R2 / R3 / R4: nibble-wise writes, neighbours kept
    st('hF4, 5); st('hF5, 'hA); st('hF6, 3);
    chk("R2", "ta_out assembled", int'(ta_out), 'h3A5);
    st('hF5, 0);
    chk("R2", "ta mid only", int'(ta_out), 'h305);
    st('hF8, 'hC); st('hFA, 7); st('hF9, 1);
    chk("R3", "tb_out assembled", int'(tb_out), 'h71C);
    st('hFE, 'hF); st('hFC, 2); st('hFD, 9);
    chk("R4", "dp_out assembled", int'(dp_out), 'hF92);
    // R5: stack pointer
    st('hFF, 'hB);
    chk("R5", "sp_out", int'(sp_out), 'hB);
    ld('hFF);
    // R6 / R7: loads, including a zero nibble
    ld('hF4); ld('hF5); ld('hF6);
    ld('hF8); ld('hF9); ld('hFA); ld('hFC); ld('hFD); ld('hFE);
    // store then load of same nibble in the next cycle
    st('hF9, 0); ld('hF9);
    // R8: store strobes only status
    issue(1, 'h69, 'hF6, 6, "R8");
    // R10: unlisted codes and unknown first byte
    issue(1, 'h69, 'hF7, 'hE, "R10");
    issue(1, 'h69, 'hFB, 'hE, "R10");
    issue(1, 'h69, 'hF0, 'hE, "R10");
    issue(1, 'h69, 'hE4, 'hE, "R10");
    issue(1, 'h6A, 'hF3, 0, "R10");
    issue(1, 'h6B, 'hF4, 'hE, "R10");
    // R11: valid low
    issue(0, 'h69, 'hF4, 'hE, "R11");
    issue(0, 'h6A, 'hFF, 0, "R11");

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int r, b1, b2;
      r = $urandom_range(0, 9);
      b1 = (r < 4) ? 'h6A : (r < 8) ? 'h69 : (r == 8) ? 'h6B : 'h00;
      b2 = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 255) : ('hF0 | $urandom_range(0, 15));
      issue($urandom_range(0, 7) != 0, b1, b2, $urandom_range(0, 15), "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule